// File: doc/BRIEF.md
# Broadcast-Sample Convolver with Rotating Tagged Weights

This block computes a one-dimensional convolution, y_i = w1·x_i + w2·x_(i+1) + … + wK·x_(i+K-1), on a row of K multiply-accumulate cells. Every accepted sample goes to all cells in the same cycle. Each output y_i belongs to one cell, and that cell builds the whole sum in a local accumulator. The accumulator is wider than the operands. The weights do not stay in place: they rotate around a ring of cells by one position for each accepted sample. The position that holds w1 carries a marker bit. When the marker reaches a cell, that cell puts its finished sum onto a shared result bus and starts a new sum.

The weights are loaded first, one per cycle, in the order w1, w2, …, wK. A load also clears every accumulator and restarts the sample count. After that, the samples stream in with a valid qualifier. Results come out in natural order (y_0, y_1, …) with a valid strobe. All arithmetic is signed two's complement.

Top module: `bconv_top`

## Requirements
- R1: After synchronous reset, `res_valid` is low and stays low until K+1 samples have been accepted.
- R2: Each cycle with `wt_load` high stores `wt_data` as the next weight (w1 first, then w2, up to wK, then the count wraps to w1). A load also clears all accumulators and restarts the sample count at zero.
- R3: The result for index i equals the sum over m = 1..K of w_m · x_(i+m-1). Samples, weights and results are signed two's complement.
- R4: The result y_i appears with `res_valid` high in the cycle that follows the clock edge accepting sample x_(i+K), counted from the last load. Results come out in increasing i.
- R5: The first K samples accepted after a load produce no result.
- R6: A cycle with `smp_valid` low leaves all state unchanged and produces no result. Gaps in the stream do not change any result value.
- R7: A sample presented in the same cycle as `wt_load` is ignored. It neither enters any sum nor counts toward R4/R5.
- R8: The result width is XW+WW+ceil(log2 K) bits, so K products of extreme operands (e.g. −128·−128 for 8-bit inputs) are exact.
- R9: In any cycle, at most one cell places its sum on the result bus.
- R10: Exactly one ring position carries the w1 marker. On each accepted sample, every weight moves one cell onward and the last cell wraps to the first.
- R11: `res_valid` is high only in the cycle after an accepted sample, and never in the cycle right after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wt_load | input | 1 | Store `wt_data` as the next weight in sequence |
| wt_data | input | WW | Signed weight value |
| smp_valid | input | 1 | Sample present on `smp_data` |
| smp_data | input | XW | Signed sample, broadcast to all cells |
| res_valid | output | 1 | Result strobe |
| res_data | output | XW+WW+ceil(log2 K) | Signed convolution result |

## Verification
The bench targets the restart boundary, where a cell swaps a finished sum for a new product. An off-by-one ring direction or wrong load slot there gives the weights in reversed or shifted order and a plausible but wrong sum. It streams with idle gaps, which catches any design that rotates or accumulates on cycles without a sample. It reloads weights while samples are asserted, which exposes a design that lets a dropped sample leak into a sum or leaves stale partial sums behind. Extreme operand runs expose an accumulator that is too narrow or not sign-extended: that design wraps to the wrong sign.

// File: rtl/bconv_pkg.sv
package bconv_pkg;

  typedef enum logic [1:0] {
    CELL_HOLD,
    CELL_ACCUM,
    CELL_RESTART,
    CELL_CLEAR
  } cell_op_e;

  // ring neighbour feeding cell idx on each rotation
  function automatic int prev_cell(input int idx, input int k);
    return (idx == 0) ? k - 1 : idx - 1;
  endfunction

  // ring slot that must hold weight number ptr (0-based) at sample zero
  function automatic int load_slot(input int ptr, input int k);
    return (ptr == 0) ? 0 : k - ptr;
  endfunction

  // guard bits for summing k products
  function automatic int guard_bits(input int k);
    return (k > 1) ? $clog2(k) : 0;
  endfunction

endpackage

// File: rtl/bconv_weight_ring.sv
module bconv_weight_ring
  import bconv_pkg::*;
#(
  parameter int K  = 3,
  parameter int WW = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [WW-1:0]          load_data,
  input  logic                   step,
  output logic [K-1:0][WW-1:0]   w_out,
  output logic [K-1:0]           tag_out
);
  localparam int PW = (K > 1) ? $clog2(K) : 1;

  logic [K-1:0][WW-1:0] w_q;
  logic [K-1:0]         tag_q;
  logic [PW-1:0]        ptr_q;
  logic [PW-1:0]        slot_idx;
  logic                 ptr_last;

  always_comb begin
    slot_idx = PW'(load_slot(int'(ptr_q), K));
    ptr_last = (int'(ptr_q) == K - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      tag_q <= K'(1);
      for (int c = 0; c < K; c++) w_q[c] <= '0;
    end else if (load) begin
      w_q[slot_idx] <= load_data;
      ptr_q         <= ptr_last ? '0 : ptr_q + 1'b1;
      tag_q         <= K'(1);
    end else if (step) begin
      for (int c = 0; c < K; c++) begin
        w_q[c]   <= w_q[prev_cell(c, K)];
        tag_q[c] <= tag_q[prev_cell(c, K)];
      end
    end
  end

  assign w_out   = w_q;
  assign tag_out = tag_q;

  // R10
  tag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(tag_q));

  // R10
  ring_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (w_q[0] == $past(w_q[K-1])));

  // R2
  tag_home_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> tag_q[0]);

endmodule

// File: rtl/bconv_cell.sv
module bconv_cell
  import bconv_pkg::*;
#(
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [XW-1:0] sample,
  input  logic [WW-1:0] weight,
  input  logic          tag,
  output logic [AW-1:0] acc,
  output logic          emit
);

  function automatic logic signed [AW-1:0] mac_term(
    input logic [XW-1:0] xs, input logic [WW-1:0] ws);
    logic signed [AW-1:0] xe;
    logic signed [AW-1:0] we;
    xe = AW'(signed'(xs));
    we = AW'(signed'(ws));
    return xe * we;
  endfunction

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] term;
  logic                 live_q;
  cell_op_e             op;

  always_comb begin
    term = mac_term(sample, weight);
    if (clear)            op = CELL_CLEAR;
    else if (step && tag) op = CELL_RESTART;
    else if (step)        op = CELL_ACCUM;
    else                  op = CELL_HOLD;
  end

  assign emit = (op == CELL_RESTART) && live_q;
  assign acc  = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      live_q <= 1'b0;
    end else begin
      case (op)
        CELL_CLEAR: begin
          acc_q  <= '0;
          live_q <= 1'b0;
        end
        CELL_RESTART: begin
          acc_q  <= term;
          live_q <= 1'b1;
        end
        CELL_ACCUM: acc_q <= acc_q + term;
        default:    acc_q <= acc_q;
      endcase
    end
  end

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !clear) |=> $stable(acc_q));

endmodule

// File: rtl/bconv_result_bus.sv
module bconv_result_bus #(
  parameter int K  = 3,
  parameter int AW = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [K-1:0]          emit,
  input  logic [K-1:0][AW-1:0]  accs,
  output logic                  res_valid,
  output logic [AW-1:0]         res_data
);
  logic [AW-1:0] sel;

  always_comb begin
    sel = '0;
    for (int c = 0; c < K; c++) sel = sel | (emit[c] ? accs[c] : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= |emit;
      if (|emit) res_data <= sel;
    end
  end

  // R9
  single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(emit));

endmodule

// File: rtl/bconv_top.sv
module bconv_top
  import bconv_pkg::*;
#(
  parameter int XW = 8,
  parameter int WW = 8,
  parameter int K  = 3
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wt_load,
  input  logic [WW-1:0]                     wt_data,
  input  logic                              smp_valid,
  input  logic [XW-1:0]                     smp_data,
  output logic                              res_valid,
  output logic [XW+WW+guard_bits(K)-1:0]    res_data
);
  localparam int AW = XW + WW + guard_bits(K);

  logic                 step;
  logic [K-1:0][WW-1:0] w_ring;
  logic [K-1:0]         tag_ring;
  logic [K-1:0][AW-1:0] accs;
  logic [K-1:0]         emit;

  assign step = smp_valid && !wt_load;

  bconv_weight_ring #(.K(K), .WW(WW)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .load      (wt_load),
    .load_data (wt_data),
    .step      (step),
    .w_out     (w_ring),
    .tag_out   (tag_ring)
  );

  for (genvar c = 0; c < K; c++) begin : g_cell
    bconv_cell #(.XW(XW), .WW(WW), .AW(AW)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .clear  (wt_load),
      .step   (step),
      .sample (smp_data),
      .weight (w_ring[c]),
      .tag    (tag_ring[c]),
      .acc    (accs[c]),
      .emit   (emit[c])
    );
  end

  bconv_result_bus #(.K(K), .AW(AW)) u_bus (
    .clk       (clk),
    .rst       (rst),
    .emit      (emit),
    .accs      (accs),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  // R11
  result_after_sample_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(smp_valid && !wt_load));

  // R5
  no_result_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    wt_load |=> !res_valid);

endmodule

// File: tb/bconv_top_tb.sv
`timescale 1ns/1ps
module bconv_top_tb;
  localparam int XW = 8;
  localparam int WW = 8;
  localparam int K  = 3;
  localparam int AW = XW + WW + 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          wt_load;
  logic [WW-1:0] wt_data;
  logic          smp_valid;
  logic [XW-1:0] smp_data;
  logic          res_valid;
  logic [AW-1:0] res_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  int wts[K];
  int lptr = 0;
  int xs[$];
  bit exp_v = 0;
  int exp_d = 0;

  always #2.5 clk = ~clk;

  bconv_top #(.XW(XW), .WW(WW), .K(K)) u_dut (
    .clk(clk), .rst(rst), .wt_load(wt_load), .wt_data(wt_data),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .res_valid(res_valid), .res_data(res_data)
  );

  task automatic compare(input string tag);
    int act;
    act = int'($signed(res_data));
    compared++;
    if (res_valid !== exp_v) begin
      mismatched++;
      $display("FAIL %s: res_valid=%0b expected %0b", tag, res_valid, exp_v);
    end else if (exp_v && act != exp_d) begin
      mismatched++;
      $display("FAIL %s: res_data=%0d expected %0d", tag, act, exp_d);
    end
  endtask

  task automatic drive(input bit ld, input int ldv, input bit sv,
                       input int sdv, input string tag);
    int sum;
    int base;
    wt_load   = ld;
    wt_data   = ldv[WW-1:0];
    smp_valid = sv;
    smp_data  = sdv[XW-1:0];
    @(posedge clk);
    if (ld) begin
      wts[lptr] = ldv;
      lptr = (lptr + 1) % K;
      xs.delete();
      exp_v = 0;
    end else if (sv) begin
      xs.push_back(sdv);
      if (xs.size() > K) begin
        base = xs.size() - 1 - K;
        sum = 0;
        for (int m = 0; m < K; m++) sum += wts[m] * xs[base + m];
        exp_v = 1;
        exp_d = sum;
      end else begin
        exp_v = 0;
      end
    end else begin
      exp_v = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  function automatic int pat(input int i);
    return ((i * 37 + 11) % 256) - 128;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < K; m++) wts[m] = 0;
    rst = 1'b1; wt_load = 0; wt_data = '0; smp_valid = 0; smp_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_v = 0;
    compare("R1");
    rst = 1'b0;

    // R1: samples with all-zero weights, nothing before K+1 samples
    for (int i = 0; i < K; i++) drive(0, 0, 1, pat(i), "R1");

    // R2: load w1..wK
    drive(1, 3, 0, 0, "R2");
    drive(1, -5, 0, 0, "R2");
    drive(1, 7, 0, 0, "R2");

    // R3 R4 R5: continuous stream
    for (int i = 0; i < 24; i++) drive(0, 0, 1, pat(i), "R3");

    // R6: gaps between samples
    for (int i = 0; i < 16; i++) begin
      drive(0, 0, 1, pat(i + 40), "R6");
      drive(0, 0, 0, 99, "R6");
      if (i % 3 == 0) drive(0, 0, 0, -7, "R6");
    end

    // R7: reload with samples asserted alongside
    drive(1, -2, 1, 55, "R7");
    drive(1, 9, 1, -66, "R7");
    drive(1, 4, 1, 77, "R7");
    for (int i = 0; i < 12; i++) drive(0, 0, 1, pat(i + 90), "R5");

    // R8: extreme operands
    drive(1, -128, 0, 0, "R8");
    drive(1, -128, 0, 0, "R8");
    drive(1, -128, 0, 0, "R8");
    for (int i = 0; i < 7; i++) drive(0, 0, 1, -128, "R8");
    drive(1, 127, 0, 0, "R8");
    drive(1, 127, 0, 0, "R8");
    drive(1, 127, 0, 0, "R8");
    for (int i = 0; i < 7; i++) drive(0, 0, 1, -128, "R8");
    for (int i = 0; i < 5; i++) drive(0, 0, 1, 127, "R8");

    // R4: trailing idle, no spurious results
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, "R4");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule